// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Sequencer

This block serves a single dual-purpose board pin on a clock generator. After reset the pin is an active-low power-good strobe. The first cycle in which it is sampled low captures a three-bit frequency-select strap and a two-bit function-select strap. From then on the pin is an active-high power-down request. Further strap and strobe activity is ignored unless test mode is active. In test mode a low pin captures the straps again and is never taken as power-down.

The captured frequency strap is decoded into a CPU frequency code. The function straps are passed out as routing selects, and all captured values are exported as read-only status. A qualified power-down request parks the outputs. Single-ended outputs are held low from their next falling edge. Differential pairs park on the next falling edge of the complement clock, in the leg pattern that each pair's drive-mode bit selects. Once everything is parked the PLL enable drops. When the request clears, the PLL enable rises again, and the outputs are released only after lock, each on a falling edge of its own clock.

Top module: `pwrgood_strap_seq`

## Requirements
- R1: During and right after reset: strap_done=0, fs_status=0, fn_status=0, pd_active=0, se_hold=0, every dif_t_oe and dif_c_oe bit is 1, dif_t_high=0 and pll_en=1.
- R2: The first rising clock edge that samples pgpd_pin low copies fs_strap into fs_status and fn_strap into fn_status, and strap_done goes to 1 after that edge.
- R3: Once strap_done is 1 and test_mode is 0, changes on pgpd_pin, fs_strap or fn_strap leave fs_status and fn_status unchanged.
- R4: While test_mode is 1, every edge that samples pgpd_pin low recaptures both straps, and pd_active stays 0 whatever the pin does.
- R5: cpu_freq decodes fs_status (bit 2, bit 1, bit 0) as: 101 gives 0 (100 MHz), 001 gives 1 (133 MHz), 011 gives 2 (166 MHz), 010 gives 3 (200 MHz). freq_legal is 1 for these four codes only, and cpu_freq is 0 otherwise.
- R6: pair_27m_sel equals fn_status bit 0 (1 = the shared pair carries the 27 MHz clocks, 0 = the 96 MHz dot clock). pair_cpu_sel equals fn_status bit 1 (1 = CPU clock, 0 = SRC clock).
- R7: After capture, with test_mode 0, pd_active becomes 1 after two consecutive rising edges sample pgpd_pin high. It becomes 0 after the first edge that samples the pin low.
- R8: After pd_active is seen, se_hold rises on the first edge where se_clk_lvl was sampled 1 on the previous edge and 0 on this one.
- R9: After pd_active is seen, the differential pairs park on the first falling edge of dif_c_lvl detected the same way. A parked pair i has dif_c_oe[i]=0. If dif_drive_mode[i]=0, its true leg is driven high (dif_t_oe[i]=1, dif_t_high[i]=1). If dif_drive_mode[i]=1, both legs are off (dif_t_oe[i]=0, dif_t_high[i]=0).
- R10: pll_en drops to 0 once both se_hold and the pair park are set, and returns to 1 after pd_active has returned to 0.
- R11: After power-down clears, se_hold and the pair park stay set until pll_lock is 1. Each is then released on a falling edge of its own clock, and the block returns to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (complement-clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgpd_pin | input | 1 | Dual pin: active-low power-good, then active-high power-down |
| test_mode | input | 1 | Keeps strap capture open and disables power-down |
| fs_strap | input | 3 | Frequency-select strap |
| fn_strap | input | 2 | Function-select strap |
| se_clk_lvl | input | 1 | Level of the single-ended output clock |
| dif_c_lvl | input | 1 | Level of the differential complement clock |
| pll_lock | input | 1 | PLL lock indication |
| dif_drive_mode | input | NUM_DIF | Per-pair park mode, 1 = both legs off |
| strap_done | output | 1 | Straps have been captured |
| fs_status | output | 3 | Captured frequency strap |
| fn_status | output | 2 | Captured function strap |
| cpu_freq | output | 2 | Decoded CPU frequency code |
| freq_legal | output | 1 | Captured frequency strap is a defined code |
| pair_27m_sel | output | 1 | Shared pair carries 27 MHz clocks |
| pair_cpu_sel | output | 1 | Selectable pair is a CPU clock |
| pd_active | output | 1 | Qualified power-down request |
| se_hold | output | 1 | Hold single-ended outputs low |
| dif_t_oe | output | NUM_DIF | True-leg output enable per pair |
| dif_c_oe | output | NUM_DIF | Complement-leg output enable per pair |
| dif_t_high | output | NUM_DIF | Force true leg high per pair |
| pll_en | output | 1 | PLL power enable |

## Verification
Assertions check on every cycle several edge rules. Captured straps stay still once capture has closed outside test mode. A rising pd_active follows a high pin sample. se_hold and the pair park change only on edges that come right after a falling clock level. The PLL is never off unless every output is parked. A release needs lock. The bench scenarios are needed for the rest: the two-sample qualification count, the frequency decode of every code, the leg pattern chosen by each drive-mode bit, the wait for lock, and the re-arming of capture in test mode. The cycle-by-cycle model compared at every clock is what shows these.

// File: rtl/pgsl_pkg.sv
package pgsl_pkg;
  localparam int FS_W = 3;
  localparam int FN_W = 2;

  typedef enum logic [1:0] {
    FREQ_100 = 2'd0,
    FREQ_133 = 2'd1,
    FREQ_166 = 2'd2,
    FREQ_200 = 2'd3
  } cpu_freq_e;

  typedef enum logic [2:0] {
    SQ_RUN    = 3'd0,
    SQ_PARK   = 3'd1,
    SQ_DOWN   = 3'd2,
    SQ_RELOCK = 3'd3,
    SQ_UNPARK = 3'd4
  } seq_state_e;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import pgsl_pkg::*;
#(
  parameter int PD_QUAL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_i,
  input  logic            test_mode_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic [FN_W-1:0] fn_i,
  output logic            strap_done_o,
  output logic [FS_W-1:0] fs_o,
  output logic [FN_W-1:0] fn_o,
  output logic            pd_seen_o
);
  localparam int CNT_W = $clog2(PD_QUAL + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PD_QUAL);

  logic            done_q, done_d;
  logic [FS_W-1:0] fs_q, fs_d;
  logic [FN_W-1:0] fn_q, fn_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            capture, armed;

  always_comb begin
    capture = ~pin_i & (~done_q | test_mode_i);
    armed   = done_q & ~test_mode_i;
    done_d  = done_q | capture;
    fs_d    = capture ? fs_i : fs_q;
    fn_d    = capture ? fn_i : fn_q;
    if (armed && pin_i)
      cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fs_q   <= '0;
      fn_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= done_d;
      fs_q   <= fs_d;
      fn_q   <= fn_d;
      cnt_q  <= cnt_d;
    end
  end

  assign strap_done_o = done_q;
  assign fs_o         = fs_q;
  assign fn_o         = fn_q;
  assign pd_seen_o    = (cnt_q == CNT_TOP);

  // R2
  strap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  // R3
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !test_mode_i) |=> ($stable(fs_q) && $stable(fn_q)));
  // R7
  pd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_seen_o) |-> $past(pin_i));
  // R7
  pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_seen_o && !pin_i) |=> !pd_seen_o);
  // R4
  pd_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i |=> !pd_seen_o);
endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import pgsl_pkg::*;
(
  input  logic [FS_W-1:0] fs_i,
  output cpu_freq_e       freq_o,
  output logic            legal_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (fs_i)
      3'b101:  freq_o = FREQ_100;
      3'b001:  freq_o = FREQ_133;
      3'b011:  freq_o = FREQ_166;
      3'b010:  freq_o = FREQ_200;
      default: begin
        freq_o  = FREQ_100;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pgsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_seen_i,
  input  logic se_lvl_i,
  input  logic dif_lvl_i,
  input  logic pll_lock_i,
  output logic se_hold_o,
  output logic dif_park_o,
  output logic pll_en_o
);
  seq_state_e st_q, st_d;
  logic hold_q, hold_d, park_q, park_d;
  logic se_prev_q, dif_prev_q;
  logic se_fall, dif_fall;

  assign se_fall  = se_prev_q & ~se_lvl_i;
  assign dif_fall = dif_prev_q & ~dif_lvl_i;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    park_d = park_q;
    case (st_q)
      SQ_RUN: begin
        if (pd_seen_i) st_d = SQ_PARK;
      end
      SQ_PARK: begin
        hold_d = hold_q | se_fall;
        park_d = park_q | dif_fall;
        if (hold_d && park_d) st_d = SQ_DOWN;
      end
      SQ_DOWN: begin
        if (!pd_seen_i) st_d = SQ_RELOCK;
      end
      SQ_RELOCK: begin
        if (pll_lock_i) st_d = SQ_UNPARK;
      end
      SQ_UNPARK: begin
        if (!pll_lock_i) begin
          st_d = SQ_RELOCK;
        end else begin
          if (se_fall)  hold_d = 1'b0;
          if (dif_fall) park_d = 1'b0;
          if (!hold_d && !park_d) st_d = SQ_RUN;
        end
      end
      default: st_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_RUN;
      hold_q     <= 1'b0;
      park_q     <= 1'b0;
      se_prev_q  <= 1'b0;
      dif_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      hold_q     <= hold_d;
      park_q     <= park_d;
      se_prev_q  <= se_lvl_i;
      dif_prev_q <= dif_lvl_i;
    end
  end

  assign se_hold_o  = hold_q;
  assign dif_park_o = park_q;
  assign pll_en_o   = (st_q != SQ_DOWN);

  // R8
  se_hold_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> ($past(se_lvl_i, 2) && !$past(se_lvl_i)));
  // R9
  dif_park_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> ($past(dif_lvl_i, 2) && !$past(dif_lvl_i)));
  // R10
  pll_off_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en_o |-> (hold_q && park_q));
  // R11
  se_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(pll_lock_i) && !$past(se_lvl_i)));
  // R11
  dif_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(park_q) |-> ($past(pll_lock_i) && !$past(dif_lvl_i)));
endmodule

// File: rtl/pwrgood_strap_seq.sv
module pwrgood_strap_seq
  import pgsl_pkg::*;
#(
  parameter int NUM_DIF = 3,
  parameter int PD_QUAL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pgpd_pin,
  input  logic               test_mode,
  input  logic [2:0]         fs_strap,
  input  logic [1:0]         fn_strap,
  input  logic               se_clk_lvl,
  input  logic               dif_c_lvl,
  input  logic               pll_lock,
  input  logic [NUM_DIF-1:0] dif_drive_mode,
  output logic               strap_done,
  output logic [2:0]         fs_status,
  output logic [1:0]         fn_status,
  output logic [1:0]         cpu_freq,
  output logic               freq_legal,
  output logic               pair_27m_sel,
  output logic               pair_cpu_sel,
  output logic               pd_active,
  output logic               se_hold,
  output logic [NUM_DIF-1:0] dif_t_oe,
  output logic [NUM_DIF-1:0] dif_c_oe,
  output logic [NUM_DIF-1:0] dif_t_high,
  output logic               pll_en
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       pd_seen;
  logic       dif_park;
  cpu_freq_e  freq_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  strap_latch #(.PD_QUAL(PD_QUAL)) u_straps (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .pin_i        (pgpd_pin),
    .test_mode_i  (test_mode),
    .fs_i         (fs_strap),
    .fn_i         (fn_strap),
    .strap_done_o (strap_done),
    .fs_o         (fs_status),
    .fn_o         (fn_status),
    .pd_seen_o    (pd_seen)
  );

  freq_decode u_decode (
    .fs_i    (fs_status),
    .freq_o  (freq_code),
    .legal_o (freq_legal)
  );

  pd_sequencer u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .pd_seen_i  (pd_seen),
    .se_lvl_i   (se_clk_lvl),
    .dif_lvl_i  (dif_c_lvl),
    .pll_lock_i (pll_lock),
    .se_hold_o  (se_hold),
    .dif_park_o (dif_park),
    .pll_en_o   (pll_en)
  );

  assign cpu_freq     = freq_code;
  assign pair_27m_sel = fn_status[0];
  assign pair_cpu_sel = fn_status[1];
  assign pd_active    = pd_seen;

  for (genvar i = 0; i < NUM_DIF; i++) begin : g_lane
    assign dif_t_oe[i]   = ~dif_park | ~dif_drive_mode[i];
    assign dif_c_oe[i]   = ~dif_park;
    assign dif_t_high[i] = dif_park & ~dif_drive_mode[i];
  end
endmodule

// File: tb/pwrgood_strap_seq_test.sv
module pwrgood_strap_seq_test;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst_n, pgpd_pin, test_mode, se_clk_lvl, dif_c_lvl, pll_lock;
  logic [2:0] fs_strap;
  logic [1:0] fn_strap;
  logic [ND-1:0] dif_drive_mode;
  logic strap_done, freq_legal, pair_27m_sel, pair_cpu_sel, pd_active, se_hold, pll_en;
  logic [2:0] fs_status;
  logic [1:0] fn_status, cpu_freq;
  logic [ND-1:0] dif_t_oe, dif_c_oe, dif_t_high;

  pwrgood_strap_seq #(.NUM_DIF(ND), .PD_QUAL(2)) uut (
    .clk(clk), .rst_n(rst_n), .pgpd_pin(pgpd_pin), .test_mode(test_mode),
    .fs_strap(fs_strap), .fn_strap(fn_strap), .se_clk_lvl(se_clk_lvl),
    .dif_c_lvl(dif_c_lvl), .pll_lock(pll_lock), .dif_drive_mode(dif_drive_mode),
    .strap_done(strap_done), .fs_status(fs_status), .fn_status(fn_status),
    .cpu_freq(cpu_freq), .freq_legal(freq_legal), .pair_27m_sel(pair_27m_sel),
    .pair_cpu_sel(pair_cpu_sel), .pd_active(pd_active), .se_hold(se_hold),
    .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe), .dif_t_high(dif_t_high), .pll_en(pll_en)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0, ph = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int sc = 0, m_cnt = 0, m_st = 0;
  bit m_done, m_h, m_p, m_sep, m_dp;
  int m_fs = 0, m_fn = 0;

  function automatic void m_reset();
    m_done = 0; m_fs = 0; m_fn = 0; m_cnt = 0; m_st = 0;
    m_h = 0; m_p = 0; m_sep = 0; m_dp = 0;
  endfunction

  function automatic int exp_freq(input int f);
    if (f == 5) return 0;
    if (f == 1) return 1;
    if (f == 3) return 2;
    if (f == 2) return 3;
    return 0;
  endfunction

  function automatic int exp_legal(input int f);
    return (f == 5 || f == 1 || f == 3 || f == 2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sc = 0; m_reset();
    end else if (sc < 2) begin
      sc++; m_reset();
    end else begin
      bit fse, fdi, pds, armed;
      fse = m_sep && !se_clk_lvl;
      fdi = m_dp && !dif_c_lvl;
      pds = (m_cnt >= 2);
      armed = m_done && !test_mode;
      if (m_st == 0) begin
        if (pds) m_st = 1;
      end else if (m_st == 1) begin
        if (fse) m_h = 1;
        if (fdi) m_p = 1;
        if (m_h && m_p) m_st = 2;
      end else if (m_st == 2) begin
        if (!pds) m_st = 3;
      end else if (m_st == 3) begin
        if (pll_lock) m_st = 4;
      end else begin
        if (!pll_lock) m_st = 3;
        else begin
          if (fse) m_h = 0;
          if (fdi) m_p = 0;
          if (!m_h && !m_p) m_st = 0;
        end
      end
      if (!pgpd_pin && (!m_done || test_mode)) begin
        m_fs = fs_strap; m_fn = fn_strap; m_done = 1;
      end
      if (armed && pgpd_pin) m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
      else m_cnt = 0;
      m_sep = se_clk_lvl;
      m_dp = dif_c_lvl;
    end
  end

  // per-cycle comparison, then clock-level stimulus and watchdog
  always @(negedge clk) begin
    #2;
    if (!done_flag) begin
      int t_oe, c_oe, t_hi;
      t_oe = 0; c_oe = 0; t_hi = 0;
      for (int i = 0; i < ND; i++) begin
        if (!m_p || !dif_drive_mode[i]) t_oe |= (1 << i);
        if (!m_p) c_oe |= (1 << i);
        if (m_p && !dif_drive_mode[i]) t_hi |= (1 << i);
      end
      chk("R2 strap_done", strap_done, m_done);
      chk("R2 fs_status", fs_status, m_fs);
      chk("R2 fn_status", fn_status, m_fn);
      chk("R5 cpu_freq", cpu_freq, exp_freq(m_fs));
      chk("R5 freq_legal", freq_legal, exp_legal(m_fs));
      chk("R6 pair sel", {pair_cpu_sel, pair_27m_sel}, m_fn);
      chk("R7 pd_active", pd_active, (m_cnt >= 2));
      chk("R8 se_hold", se_hold, m_h);
      chk("R9 dif_t_oe", dif_t_oe, t_oe);
      chk("R9 dif_c_oe", dif_c_oe, c_oe);
      chk("R9 dif_t_high", dif_t_high, t_hi);
      chk("R10 pll_en", pll_en, (m_st != 2));
    end
    dif_c_lvl = ~dif_c_lvl;
    ph = (ph + 1) % 6;
    se_clk_lvl = (ph < 3);
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; pgpd_pin = 1; test_mode = 0; fs_strap = 3'b101; fn_strap = 2'b10;
    pll_lock = 1; dif_drive_mode = 3'b001; se_clk_lvl = 0; dif_c_lvl = 0;
    step(4);
    // R1 reset state
    chk("R1 strap_done", strap_done, 0);
    chk("R1 pll_en", pll_en, 1);
    chk("R1 se_hold", se_hold, 0);
    chk("R1 dif_c_oe", dif_c_oe, 7);
    rst_n = 1;
    step(5);
    chk("R1 after release dif_t_high", dif_t_high, 0);
    // R2 capture on first low sample
    pgpd_pin = 0;
    step(1);
    chk("R2 captured", strap_done, 1);
    chk("R2 fs", fs_status, 5);
    chk("R5 100MHz code", cpu_freq, 0);
    chk("R6 cpu pair", pair_cpu_sel, 1);
    chk("R6 dot pair", pair_27m_sel, 0);
    // R3 later changes ignored; R7 single high not qualified
    fs_strap = 3'b010; fn_strap = 2'b01; pgpd_pin = 1;
    step(1);
    pgpd_pin = 0;
    step(2);
    chk("R7 single high", pd_active, 0);
    chk("R3 fs frozen", fs_status, 5);
    chk("R3 fn frozen", fn_status, 2);
    // R7..R10 power-down
    pll_lock = 0;
    pgpd_pin = 1;
    step(2);
    chk("R7 qualified", pd_active, 1);
    for (int k = 0; k < 12 && pll_en; k++) step(1);
    chk("R10 pll off", pll_en, 0);
    chk("R8 se held", se_hold, 1);
    chk("R9 t_oe", dif_t_oe, 6);
    chk("R9 c_oe", dif_c_oe, 0);
    chk("R9 t_high", dif_t_high, 6);
    pgpd_pin = 0;
    step(6);
    chk("R10 pll back", pll_en, 1);
    chk("R11 wait lock hold", se_hold, 1);
    chk("R11 wait lock park", dif_c_oe, 0);
    pll_lock = 1;
    for (int k = 0; k < 16 && (se_hold || dif_c_oe != 3'b111); k++) step(1);
    chk("R11 se released", se_hold, 0);
    chk("R11 pairs released", dif_c_oe, 7);
    // R4 test mode recapture and R5 codes
    test_mode = 1;
    fs_strap = 3'b011; step(2);
    chk("R4 recapture", fs_status, 3);
    chk("R5 166MHz code", cpu_freq, 2);
    fs_strap = 3'b010; step(2);
    chk("R5 200MHz code", cpu_freq, 3);
    fs_strap = 3'b001; step(2);
    chk("R5 133MHz code", cpu_freq, 1);
    fs_strap = 3'b111; step(2);
    chk("R5 illegal", freq_legal, 0);
    chk("R5 illegal code", cpu_freq, 0);
    pgpd_pin = 1; step(5);
    chk("R4 no pd in test", pd_active, 0);
    chk("R4 no hold in test", se_hold, 0);
    // back to normal: capture closed again
    test_mode = 0; pgpd_pin = 0; fs_strap = 3'b101; step(3);
    chk("R3 closed after test", fs_status, 7);
    step(2);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule